// File: doc/BRIEF.md
# Bidirectional Stream Prefetch Engine

This engine sits next to a second-level cache and watches every read lookup that arrives there from the first-level caches. The watched lookups are load reads, store reads, requests from first-level hardware prefetchers and instruction fetches. For each 4 KB page that is being touched, it keeps a small tracker. The tracker learns whether the accesses in that page walk upward or downward one line at a time. Once a direction has been seen twice in a row, every later lookup to that page may produce up to two prefetch line addresses. These addresses run ahead of the demand in the learned direction.

Prefetches never leave the page of the triggering lookup. They never run more than a fixed number of lines ahead of the most recent demand line. They pass through a short queue to a valid/ready output. When the queue is full, the surplus requests are dropped and the lookup input is never held back. The frontier only moves for requests that were actually queued, so a later lookup produces the dropped requests again.

Top module: `stream_pf`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `pf_valid` is 0 and no tracker is in use.
- R2: The lookup kind (`lk_kind`: 0 load, 1 store, 2 first-level prefetch, 3 instruction fetch) has no effect; every kind trains and triggers in the same way.
- R3: The page number is `lk_line[LINE_AW-1:6]` and the line index is `lk_line[5:0]`. After lookups to indices L, L+1 and L+2 of one page, the third lookup queues L+3 and then L+4. Lookups before the third queue nothing.
- R4: Descending runs L, L-1, L-2 queue L-3 and then L-4, in that order.
- R5: A candidate line outside indices 0..63 of the lookup's page is never queued. The nearer candidate is always tried first, and the farther one is queued only if the nearer one was.
- R6: A lookup queues at most two requests. A cycle without a lookup queues none.
- R7: A queued line index is never more than MAX_AHEAD (20) lines from the index of the lookup that queued it. Repeated lookups to the same line stop producing requests at that limit.
- R8: There are NTRK (8) trackers. A lookup to a page that has no tracker takes one in round-robin order, starting from slot 0 after reset. The ninth new page evicts the first page's training.
- R9: A lookup whose index differs from the tracker's last index by more than one line clears the learned direction. A one-line step against the learned direction also clears it. Two new steps in one direction are then needed before any request is queued again.
- R10: The output queue holds QDEPTH (4) entries. Requests that do not fit are dropped and the frontier does not move past them, so a later lookup queues them again.
- R11: A queued request stays on `pf_line` with `pf_valid` high until `pf_ready` is seen, and requests leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | A lookup is present this cycle |
| lk_line | input | LINE_AW | Line address of the lookup |
| lk_kind | input | 2 | Kind of lookup (0 load, 1 store, 2 first-level prefetch, 3 instruction fetch) |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | LINE_AW | Line address to prefetch |
| pf_ready | input | 1 | The request is taken this cycle |

## Verification
A tracker holding a wrong last line, direction or confirmation flag shows up on the first later lookup to its page. The symptom is a missing pair of requests, an extra pair, or lines on the wrong side of the demand, and it appears one cycle after that lookup. A frontier that advanced too far or not far enough shows as a gap or a repeated line in the output stream. This only becomes visible once the queue has backed up and then drained. A bench model is compared every cycle for this reason, and the drained line sequences are also checked against hand-derived lists.

// File: rtl/stream_pf.sv
module stream_pf #(
  parameter int LINE_AW    = 26,
  parameter int PAGE_LINES = 64,
  parameter int NTRK       = 8,
  parameter int MAX_AHEAD  = 20,
  parameter int QDEPTH     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [LINE_AW-1:0] lk_line,
  input  logic [1:0]         lk_kind,
  output logic               pf_valid,
  output logic [LINE_AW-1:0] pf_line,
  input  logic               pf_ready
);
  localparam int IW = $clog2(PAGE_LINES);
  localparam int PW = LINE_AW - IW;
  localparam int TW = $clog2(NTRK);
  localparam int QW = $clog2(QDEPTH);
  localparam int SW = IW + 3;
  typedef logic signed [SW-1:0] sidx_t;

  logic [NTRK-1:0] t_val, t_conf;
  logic [PW-1:0]   t_page  [NTRK];
  logic [IW-1:0]   t_last  [NTRK];
  logic [IW-1:0]   t_front [NTRK];
  logic [1:0]      t_dir   [NTRK];
  logic [TW-1:0]   rr;

  logic [LINE_AW-1:0] q_mem [QDEPTH];
  logic [QW-1:0]      wp, rp;
  logic [QW:0]        q_cnt, free;

  logic unused_kind;
  assign unused_kind = &{1'b0, lk_kind};

  wire [PW-1:0] lk_page = lk_line[LINE_AW-1:IW];
  wire [IW-1:0] lk_idx  = lk_line[IW-1:0];

  logic [NTRK-1:0] hit_vec;
  logic [TW-1:0]   hit_id;
  for (genvar g = 0; g < NTRK; g++) begin : g_match
    assign hit_vec[g] = t_val[g] && (t_page[g] == lk_page);
  end
  always_comb begin
    hit_id = '0;
    for (int i = NTRK - 1; i >= 0; i--)
      if (hit_vec[i]) hit_id = TW'(i);
  end
  wire hit = |hit_vec;

  sidx_t idx_s, last_s, front_s, dir_s, delta, nd_s, fb, c1, c2, nf;
  logic [1:0] n_dir;
  logic       n_conf;

  assign idx_s   = sidx_t'(lk_idx);
  assign last_s  = sidx_t'(t_last[hit_id]);
  assign front_s = sidx_t'(t_front[hit_id]);
  assign dir_s   = sidx_t'($signed(t_dir[hit_id]));
  assign delta   = idx_s - last_s;

  always_comb begin
    n_dir  = t_dir[hit_id];
    n_conf = t_conf[hit_id];
    if (delta == 1 || delta == -1) begin
      n_conf = (delta == dir_s);
      n_dir  = delta[1:0];
    end else if (delta != 0) begin
      n_dir  = 2'b00;
      n_conf = 1'b0;
    end
  end

  assign nd_s = sidx_t'($signed(n_dir));

  always_comb begin
    if (!n_conf)        fb = idx_s;
    else if (nd_s > 0)  fb = (front_s > idx_s) ? front_s : idx_s;
    else                fb = (front_s < idx_s) ? front_s : idx_s;
  end

  assign c1 = fb + nd_s;
  assign c2 = c1 + nd_s;

  function automatic logic in_reach(sidx_t c, sidx_t d);
    return (c >= 0) && (c < PAGE_LINES) && (c - d <= MAX_AHEAD) && (d - c <= MAX_AHEAD);
  endfunction

  assign free = (QW+1)'(QDEPTH) - q_cnt;
  wire do_look = lk_valid && hit && n_conf;
  wire push1   = do_look && in_reach(c1, idx_s) && (free != 0);
  wire push2   = push1 && in_reach(c2, idx_s) && (free > 1);
  assign nf    = push2 ? c2 : (push1 ? c1 : fb);
  wire pop     = pf_valid && pf_ready;

  logic unused_hi;
  assign unused_hi = ^{c1[SW-1:IW], c2[SW-1:IW], nf[SW-1:IW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_val  <= '0;
      t_conf <= '0;
      rr     <= '0;
      for (int i = 0; i < NTRK; i++) begin
        t_page[i]  <= '0;
        t_last[i]  <= '0;
        t_front[i] <= '0;
        t_dir[i]   <= '0;
      end
    end else if (lk_valid) begin
      if (hit) begin
        t_last[hit_id]  <= lk_idx;
        t_dir[hit_id]   <= n_dir;
        t_conf[hit_id]  <= n_conf;
        t_front[hit_id] <= nf[IW-1:0];
      end else begin
        t_val[rr]   <= 1'b1;
        t_page[rr]  <= lk_page;
        t_last[rr]  <= lk_idx;
        t_front[rr] <= lk_idx;
        t_dir[rr]   <= 2'b00;
        t_conf[rr]  <= 1'b0;
        rr          <= rr + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      q_cnt <= '0;
    end else begin
      if (push1) q_mem[wp] <= {lk_page, c1[IW-1:0]};
      if (push2) q_mem[wp + QW'(1)] <= {lk_page, c2[IW-1:0]};
      wp    <= wp + QW'(push1) + QW'(push2);
      rp    <= rp + QW'(pop);
      q_cnt <= q_cnt + (QW+1)'(push1) + (QW+1)'(push2) - (QW+1)'(pop);
    end
  end

  assign pf_valid = (q_cnt != 0);
  assign pf_line  = q_mem[rp];
endmodule

// File: rtl/stream_pf_chk.sv
module stream_pf_chk #(
  parameter int LINE_AW = 26,
  parameter int QDEPTH  = 4,
  localparam int QW     = $clog2(QDEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [LINE_AW-1:0] pf_line,
  input logic [QW:0]        q_cnt
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pf_valid);

  // R11
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QDEPTH);

  // R6
  two_per_look_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= $past(q_cnt) + 2);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> q_cnt <= $past(q_cnt));
endmodule

bind stream_pf stream_pf_chk #(.LINE_AW(LINE_AW), .QDEPTH(QDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_line(pf_line), .q_cnt(q_cnt));

// File: tb/stream_pf_tb.sv
module stream_pf_tb_top;
  localparam int LINE_AW = 26;
  localparam int DEPTH   = 4;
  localparam int AHEAD   = 20;

  logic clk = 0, rst_n = 0, lk_valid = 0, pf_ready = 1, pf_valid;
  logic [LINE_AW-1:0] lk_line = '0, pf_line;
  logic [1:0] lk_kind = '0;

  always #10 clk = ~clk;

  stream_pf dut_i (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line),
    .lk_kind(lk_kind), .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready));

  int nchk = 0, nfail = 0, cyc = 0;
  string phase = "R1";
  int log_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ln(int pg, int ix);
    return pg * 64 + ix;
  endfunction

  // behavioural model
  int mv[8], mpg[8], mlast[8], mfront[8], mdir[8], mconf[8];
  int mrr;
  int mq[$];
  int m_pg, m_ix, m_h, m_d, m_free, m_n, m_c;
  bit m_pop, m_go;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mv[i] = 0;
      mrr = 0;
      mq.delete();
    end else begin
      m_pop  = pf_ready && (mq.size() != 0);
      m_free = DEPTH - mq.size();
      if (m_pop) void'(mq.pop_front());
      if (lk_valid) begin
        m_pg = int'(lk_line) / 64;
        m_ix = int'(lk_line) % 64;
        m_h = -1;
        for (int i = 0; i < 8; i++) if (mv[i] != 0 && mpg[i] == m_pg) m_h = i;
        if (m_h < 0) begin
          mv[mrr] = 1; mpg[mrr] = m_pg; mlast[mrr] = m_ix; mfront[mrr] = m_ix;
          mdir[mrr] = 0; mconf[mrr] = 0;
          mrr = (mrr + 1) % 8;
        end else begin
          m_d = m_ix - mlast[m_h];
          if (m_d == 1 || m_d == -1) begin
            mconf[m_h] = (mdir[m_h] == m_d) ? 1 : 0;
            mdir[m_h] = m_d;
          end else if (m_d != 0) begin
            mdir[m_h] = 0; mconf[m_h] = 0;
          end
          mlast[m_h] = m_ix;
          if (mconf[m_h] == 0) mfront[m_h] = m_ix;
          else if (mdir[m_h] > 0) mfront[m_h] = (mfront[m_h] > m_ix) ? mfront[m_h] : m_ix;
          else mfront[m_h] = (mfront[m_h] < m_ix) ? mfront[m_h] : m_ix;
          if (mconf[m_h] != 0) begin
            m_n = 0; m_go = 1;
            for (int k = 1; k <= 2; k++) begin
              m_c = mfront[m_h] + k * mdir[m_h];
              if (m_go && m_c >= 0 && m_c < 64 && (m_c - m_ix) <= AHEAD &&
                  (m_ix - m_c) <= AHEAD && m_n < m_free) begin
                mq.push_back(ln(m_pg, m_c));
                m_n++;
              end else m_go = 0;
            end
            mfront[m_h] = mfront[m_h] + m_n * mdir[m_h];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(pf_valid === (mq.size() != 0), phase, longint'(pf_valid), longint'(mq.size() != 0));
      if (mq.size() != 0)
        chk(int'(pf_line) == mq[0], phase, longint'(pf_line), longint'(mq[0]));
      if (pf_valid && pf_ready) log_q.push_back(int'(pf_line));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic look(input int pg, input int ix, input int kd);
    @(posedge clk); #2;
    lk_valid = 1; lk_line = LINE_AW'(ln(pg, ix)); lk_kind = 2'(kd);
    @(posedge clk); #2;
    lk_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(3);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(pf_valid == 0, "R1", longint'(pf_valid), 0);

    phase = "R3"; log_q.delete();
    look(5, 10, 0); look(5, 11, 1); idle(3);
    chk(log_q.size() == 0, "R3", log_q.size(), 0);
    look(5, 12, 2); idle(4);
    chk(log_q.size() == 2, "R3", log_q.size(), 2);
    chk(log_q[0] == ln(5, 13), "R3", log_q[0], ln(5, 13));
    chk(log_q[1] == ln(5, 14), "R2", log_q[1], ln(5, 14));

    phase = "R7"; log_q.delete();
    repeat (15) look(5, 12, 3);
    idle(4);
    chk(log_q.size() == 18, "R7", log_q.size(), 18);
    chk(log_q[17] == ln(5, 32), "R7", log_q[17], ln(5, 32));

    phase = "R4"; log_q.delete();
    look(7, 40, 1); look(7, 39, 1); look(7, 38, 1); idle(4);
    chk(log_q.size() == 2, "R4", log_q.size(), 2);
    chk(log_q[0] == ln(7, 37), "R4", log_q[0], ln(7, 37));
    chk(log_q[1] == ln(7, 36), "R4", log_q[1], ln(7, 36));

    phase = "R5"; log_q.delete();
    look(3, 60, 0); look(3, 61, 0); look(3, 62, 0); look(3, 63, 0); idle(4);
    chk(log_q.size() == 1, "R5", log_q.size(), 1);
    chk(log_q[0] == ln(3, 63), "R5", log_q[0], ln(3, 63));

    phase = "R9"; log_q.delete();
    look(9, 20, 0); look(9, 21, 0); look(9, 22, 0); look(9, 21, 0); idle(4);
    chk(log_q.size() == 2, "R9", log_q.size(), 2);
    look(9, 20, 0); idle(4);
    chk(log_q.size() == 4, "R9", log_q.size(), 4);
    chk(log_q[2] == ln(9, 19), "R9", log_q[2], ln(9, 19));
    chk(log_q[3] == ln(9, 18), "R9", log_q[3], ln(9, 18));
    look(9, 50, 0); look(9, 51, 0); idle(4);
    chk(log_q.size() == 4, "R9", log_q.size(), 4);
    look(9, 52, 0); idle(4);
    chk(log_q.size() == 6, "R9", log_q.size(), 6);

    phase = "R10"; log_q.delete();
    pf_ready = 0;
    look(11, 0, 2); look(11, 1, 2); look(11, 2, 2); look(11, 3, 2); look(11, 4, 2);
    idle(2);
    @(negedge clk);
    chk(pf_valid == 1, "R11", longint'(pf_valid), 1);
    chk(int'(pf_line) == ln(11, 3), "R11", longint'(pf_line), ln(11, 3));
    idle(1);
    pf_ready = 1;
    idle(8);
    chk(log_q.size() == 4, "R10", log_q.size(), 4);
    chk(log_q[3] == ln(11, 6), "R11", log_q[3], ln(11, 6));
    look(11, 5, 2); idle(4);
    chk(log_q.size() == 6, "R10", log_q.size(), 6);
    chk(log_q[4] == ln(11, 7), "R10", log_q[4], ln(11, 7));
    chk(log_q[5] == ln(11, 8), "R10", log_q[5], ln(11, 8));

    phase = "R8";
    do_reset();
    log_q.delete();
    for (int p = 20; p <= 28; p++) look(p, 0, 0);
    look(22, 1, 0); look(22, 2, 0); idle(4);
    chk(log_q.size() == 2, "R8", log_q.size(), 2);
    chk(log_q[0] == ln(22, 3), "R8", log_q[0], ln(22, 3));
    look(20, 1, 0); look(20, 2, 0); idle(4);
    chk(log_q.size() == 2, "R8", log_q.size(), 2);
    look(28, 1, 0); look(28, 2, 0); idle(4);
    chk(log_q.size() == 4, "R8", log_q.size(), 4);
    chk(log_q[2] == ln(28, 3), "R8", log_q[2], ln(28, 3));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule